// File: doc/BRIEF.md
# Instruction Fetch and Address Sequencer

This block is the control sequencer of a 32-bit accumulator machine. It holds the program counter, the memory address and memory data registers, the instruction register and the index register, and it drives the single synchronous memory port. Each instruction starts with a three-cycle fetch. The sequencer then sorts the word into one of three classes: a packed pair of 16-bit instructions, a branch, or an addressed 32-bit instruction. For an addressed instruction it forms the effective address.

The sequencer completes jump, store-from-accumulator and memory increment/decrement on its own. Every other addressed operation, and the two non-addressed classes, go to an external execute unit over a request/done handshake. While that handshake is open, the operand is held on `exec_opnd_o` and the instruction word on `exec_ir_o`.

Bits are numbered from the most significant end: instruction bit k is `ir[31-k]`. Opcode bits 0 to 3 are `ir[31:28]`. Address field bits 8 to 31 are `ir[23:0]`.

Top module: `fseq_top`

## Requirements
- R1: Fetch takes three cycles. In the first, MA is loaded from PC. In the second, a read at MA loads MD and PC increments by one. In the third, IR is loaded from MD.
- R2: Memory accesses are single-cycle. In a read cycle, `mem_rd_o` is high with `mem_addr_o` = MA, and MD captures `mem_rdata_i` at that edge. In a write cycle, `mem_wr_o` is high with `mem_addr_o` = MA and `mem_wdata_o` = MD.
- R3: Instruction bit 4 = 0 marks a packed pair. The sequencer makes no further memory access and raises `exec_req_o` with `exec_kind_o` = 1 and `exec_opnd_o` equal to the fetched word.
- R4: Bit 4 = 1 with opcode bits 0 to 3 = 0111 marks a branch. The sequencer raises `exec_req_o` with `exec_kind_o` = 2 and makes no further memory access.
- R5: For an addressed instruction, bit 5 = 1 selects immediate mode. MD bits 0 to 7 are replaced by copies of bit 8. The sequencer then raises `exec_req_o` with `exec_kind_o` = 0 and makes no memory access.
- R6: Bit 7 = 1 selects indirect mode. MA takes MD bits 8 to 31, and a read at that address replaces MD with the pointer word.
- R7: Bit 6 = 1 sets the effective address to MD bits 8 to 31 plus IX bits 8 to 31, modulo 2^24. Bit 6 = 0 takes MD bits 8 to 31 unchanged. The index step follows the indirect step when both are set. IX is loaded from `ix_d_i` on any cycle that `ix_ld_i` is high.
- R8: Opcode bits 1 to 3 = 111 marks a jump. PC takes the effective address, and the next fetch reads from that address.
- R9: When opcode bits 0 and 2 are both 1 and the instruction is not a jump, the instruction is a store. It makes no operand read. MD takes `acc_i`, and MD is then written to the effective address.
- R10: When opcode bits 0 and 1 are both 1 and the instruction is neither a jump nor a store, the operand is read and then updated. Opcode bit 3 = 0 adds one and bit 3 = 1 subtracts one. The result is written back to the same address, and `zero_o` and `neg_o` take the result's all-zero and sign conditions.
- R11: Any other addressed instruction reads its operand into MD. It then raises `exec_req_o` with `exec_kind_o` = 0. The request stays high until `exec_done_i` is seen, and the next fetch follows.
- R12: While `rst_ni` is low, PC, MA, MD, IR and IX clear, and no memory or execute request is driven. The first fetch after reset reads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 24 | Memory address (MA) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 32 | Memory write data (MD) |
| mem_rdata_i | input | 32 | Memory read data, valid in the read cycle |
| acc_i | input | 32 | Accumulator value for stores |
| ix_ld_i | input | 1 | Load IX |
| ix_d_i | input | 32 | New IX value |
| exec_req_o | output | 1 | Execute request |
| exec_kind_o | output | 2 | 0 addressed op, 1 packed pair, 2 branch |
| exec_ir_o | output | 32 | Current instruction word |
| exec_opnd_o | output | 32 | Operand (MD) |
| exec_done_i | input | 1 | Execute unit finished |
| pc_o | output | 24 | Program counter |
| zero_o | output | 1 | Zero flag from increment/decrement |
| neg_o | output | 1 | Negative flag from increment/decrement |

## Verification
The assertions run on every cycle. They check that:
- the PC steps by one in the read cycle of each fetch;
- IR takes MD in the cycle after that read;
- a jump moves MA into PC;
- a store captures the accumulator into MD;
- the execute request holds until done.

The bench's scenarios cover what depends on the instruction stream. They trace the order and addresses of every memory read and write across all addressing modes, sign extension, indexed wrap, the chosen instruction class, the written data and flags, and the address of the fetch that follows a jump.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [3:0] {
    ST_FA, ST_FR, ST_FI, ST_DEC, ST_IND_A, ST_IND_R, ST_EA, ST_EXD,
    ST_ST_M, ST_ST_W, ST_OPR, ST_IDU, ST_IDW, ST_EXEC
  } state_e;

  typedef enum logic [1:0] {
    K_ADDR = 2'd0, K_PAIR = 2'd1, K_BRANCH = 2'd2
  } kind_e;

  typedef struct packed {
    logic pair;
    logic branch;
    logic imm;
    logic ind;
    logic idx;
    logic jmp;
    logic store;
    logic incdec;
    logic dec;
  } cls_t;
endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] ir_i,
  output cls_t              cls_o
);
  localparam int T = DATA_W - 1;

  logic op0, op1, op2, op3;
  assign op0 = ir_i[T];
  assign op1 = ir_i[T-1];
  assign op2 = ir_i[T-2];
  assign op3 = ir_i[T-3];

  // later tests rely on earlier ones having been taken
  always_comb begin
    cls_o.pair   = ~ir_i[T-4];
    cls_o.branch = ~op0 & op1 & op2 & op3;
    cls_o.imm    = ir_i[T-5];
    cls_o.idx    = ir_i[T-6];
    cls_o.ind    = ir_i[T-7];
    cls_o.jmp    = op1 & op2 & op3;
    cls_o.store  = op0 & op2;
    cls_o.incdec = op0 & op1;
    cls_o.dec    = op3;
  end
endmodule

// File: rtl/fseq_agen.sv
module fseq_agen #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic [DATA_W-1:0] md_i,
  input  logic [DATA_W-1:0] ix_i,
  input  logic              idx_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [DATA_W-1:0] sext_o,
  output logic [DATA_W-1:0] upd_o
);
  localparam int EXT_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] fld;
  assign fld  = md_i[ADDR_W-1:0];
  assign ea_o = idx_i ? fld + ix_i[ADDR_W-1:0] : fld;

  generate
    if (EXT_W > 0) begin : g_ext
      assign sext_o = {{EXT_W{fld[ADDR_W-1]}}, fld};
    end else begin : g_noext
      assign sext_o = md_i;
    end
  endgenerate

  assign upd_o = dec_i ? md_i - 1'b1 : md_i + 1'b1;
endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              ix_ld_i,
  input  logic [DATA_W-1:0] ix_d_i,
  output logic              exec_req_o,
  output logic [1:0]        exec_kind_o,
  output logic [DATA_W-1:0] exec_ir_o,
  output logic [DATA_W-1:0] exec_opnd_o,
  input  logic              exec_done_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              zero_o,
  output logic              neg_o
);
  state_e            state_q;
  logic [ADDR_W-1:0] pc_q, ma_q;
  logic [DATA_W-1:0] md_q, ir_q, ix_q;
  logic              zero_q, neg_q;
  cls_t              cls;
  logic [ADDR_W-1:0] ea;
  logic [DATA_W-1:0] sext, upd;

  fseq_decode #(.DATA_W(DATA_W)) u_dec (.ir_i(ir_q), .cls_o(cls));

  fseq_agen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agen (
    .md_i(md_q), .ix_i(ix_q), .idx_i(cls.idx), .dec_i(cls.dec),
    .ea_o(ea), .sext_o(sext), .upd_o(upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ix_q <= '0;
    else if (ix_ld_i) ix_q <= ix_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FA;
      pc_q    <= '0;
      ma_q    <= '0;
      md_q    <= '0;
      ir_q    <= '0;
      zero_q  <= 1'b0;
      neg_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FA: begin
          ma_q    <= pc_q;
          state_q <= ST_FR;
        end
        ST_FR: begin
          md_q    <= mem_rdata_i;
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_FI;
        end
        ST_FI: begin
          ir_q    <= md_q;
          state_q <= ST_DEC;
        end
        ST_DEC: begin
          if (cls.pair || cls.branch) state_q <= ST_EXEC;
          else if (cls.imm) begin
            md_q    <= sext;
            state_q <= ST_EXEC;
          end else if (cls.ind) state_q <= ST_IND_A;
          else state_q <= ST_EA;
        end
        ST_IND_A: begin
          ma_q    <= md_q[ADDR_W-1:0];
          state_q <= ST_IND_R;
        end
        ST_IND_R: begin
          md_q    <= mem_rdata_i;
          state_q <= ST_EA;
        end
        ST_EA: begin
          ma_q    <= ea;
          state_q <= ST_EXD;
        end
        ST_EXD: begin
          if (cls.jmp) begin
            pc_q    <= ma_q;
            state_q <= ST_FA;
          end else if (cls.store) state_q <= ST_ST_M;
          else state_q <= ST_OPR;
        end
        ST_ST_M: begin
          md_q    <= acc_i;
          state_q <= ST_ST_W;
        end
        ST_OPR: begin
          md_q    <= mem_rdata_i;
          state_q <= cls.incdec ? ST_IDU : ST_EXEC;
        end
        ST_IDU: begin
          md_q    <= upd;
          zero_q  <= (upd == '0);
          neg_q   <= upd[DATA_W-1];
          state_q <= ST_IDW;
        end
        ST_EXEC: if (exec_done_i) state_q <= ST_FA;
        default: state_q <= ST_FA;  // ST_ST_W, ST_IDW
      endcase
    end
  end

  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = md_q;
  assign mem_rd_o    = (state_q == ST_FR) || (state_q == ST_IND_R) || (state_q == ST_OPR);
  assign mem_wr_o    = (state_q == ST_ST_W) || (state_q == ST_IDW);
  assign exec_req_o  = (state_q == ST_EXEC);
  assign exec_kind_o = cls.pair ? K_PAIR : (cls.branch ? K_BRANCH : K_ADDR);
  assign exec_ir_o   = ir_q;
  assign exec_opnd_o = md_q;
  assign pc_o        = pc_q;
  assign zero_o      = zero_q;
  assign neg_o       = neg_q;

  assert_pc_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && (state_q == ST_FR) |=> pc_q == $past(pc_q) + 1'b1);

  assert_ir_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FI) |=> ir_q == $past(md_q));

  assert_jump_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXD) && cls.jmp |=> pc_q == $past(ma_q));

  assert_store_acc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ST_M) |=> mem_wr_o && (mem_wdata_o == $past(acc_i)));

  assert_exec_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_req_o && !exec_done_i |=> exec_req_o && $stable(exec_opnd_o));

  assert_no_rdwr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && !(exec_req_o && (mem_rd_o || mem_wr_o)));
endmodule

// File: tb/fseq_top_bench.sv
module fseq_top_bench;
  localparam int DW = 32;
  localparam int AW = 24;
  localparam logic [31:0] ACC = 32'hCAFE_0001;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_wr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic [DW-1:0] acc_i = ACC;
  logic          ix_ld_i = 1'b0;
  logic [DW-1:0] ix_d_i = '0;
  logic          exec_req_o;
  logic [1:0]    exec_kind_o;
  logic [DW-1:0] exec_ir_o, exec_opnd_o;
  logic          exec_done_i = 1'b0;
  logic [AW-1:0] pc_o;
  logic          zero_o, neg_o;

  fseq_top u_fseq_top (.*);

  always #2 clk_i = ~clk_i;

  logic [31:0] mem [256];
  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  always @(posedge clk_i) if (mem_wr_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;

  typedef struct {
    int          typ;  // 0 read, 1 write, 2 exec
    logic [31:0] a;
    logic [31:0] b;
    bit          fl;
    bit          z;
    bit          n;
    string       req;
  } ev_t;
  ev_t q[$];

  int errors = 0, checks = 0;
  bit running = 1'b0, ex_seen = 1'b0;
  int dcnt = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int typ, input logic [31:0] a, input logic [31:0] b, input string req,
                      input bit fl = 0, input bit z = 0, input bit n = 0);
    ev_t e;
    e.typ = typ; e.a = a; e.b = b; e.fl = fl; e.z = z; e.n = n; e.req = req;
    q.push_back(e);
  endtask

  task automatic rd(input logic [31:0] a, input string req); push(0, a, 0, req); endtask

  // monitor
  always @(negedge clk_i) begin
    if (running && q.size() > 0) begin
      ev_t e;
      if (mem_rd_o || mem_wr_o || (exec_req_o && !ex_seen)) begin
        e = q.pop_front();
        if (mem_rd_o) begin
          check(e.typ == 0, {e.req, " kind(read)"}, 0, e.typ);
          check({8'h0, mem_addr_o} == e.a, {e.req, " read addr"}, {8'h0, mem_addr_o}, e.a);
        end else if (mem_wr_o) begin
          check(e.typ == 1, {e.req, " kind(write)"}, 1, e.typ);
          check({8'h0, mem_addr_o} == e.a, {e.req, " write addr"}, {8'h0, mem_addr_o}, e.a);
          check(mem_wdata_o == e.b, {e.req, " write data"}, mem_wdata_o, e.b);
          if (e.fl) check({zero_o, neg_o} == {e.z, e.n}, {e.req, " flags"}, {30'h0, zero_o, neg_o}, {30'h0, e.z, e.n});
        end else begin
          check(e.typ == 2, {e.req, " kind(exec)"}, 2, e.typ);
          check({30'h0, exec_kind_o} == e.a, {e.req, " exec class"}, {30'h0, exec_kind_o}, e.a);
          check(exec_opnd_o == e.b, {e.req, " exec operand"}, exec_opnd_o, e.b);
        end
      end
    end
    ex_seen = exec_req_o;
  end

  // execute unit model
  always @(negedge clk_i) begin
    if (exec_req_o && !exec_done_i) begin
      dcnt++;
      if (dcnt == 3) begin exec_done_i = 1'b1; dcnt = 0; end
    end else exec_done_i = 1'b0;
  end

  function automatic logic [31:0] iw(input logic [7:0] opb, input logic [23:0] fld);
    return {opb, fld};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h00] = iw(8'h28, 24'h000040);  // direct
    mem[8'h01] = iw(8'h2C, 24'h800005);  // immediate negative
    mem[8'h02] = iw(8'h2C, 24'h000123);  // immediate positive
    mem[8'h03] = iw(8'h29, 24'h000041);  // indirect
    mem[8'h04] = iw(8'h2A, 24'h000030);  // indexed
    mem[8'h05] = iw(8'h2B, 24'h000043);  // indirect indexed
    mem[8'h06] = 32'h0123_4567;          // packed pair
    mem[8'h07] = 32'h7800_0010;          // branch
    mem[8'h08] = iw(8'hA8, 24'h000070);  // store
    mem[8'h09] = iw(8'hC8, 24'h000071);  // increment
    mem[8'h0A] = iw(8'hD8, 24'h000072);  // decrement
    mem[8'h0B] = iw(8'hDA, 24'h000063);  // decrement indexed
    mem[8'h0C] = iw(8'hF8, 24'h000020);  // jump
    mem[8'h20] = iw(8'hFA, 24'h000080);  // jump indexed
    mem[8'h90] = iw(8'h28, 24'h000040);
    mem[8'h91] = iw(8'hF8, 24'h000091);  // park
    mem[8'h40] = 32'h1122_3344;
    mem[8'h41] = 32'h0000_0042;
    mem[8'h42] = 32'hA5A5_A5A5;
    mem[8'h43] = 32'h0000_0050;
    mem[8'h60] = 32'h600D_0000;
    mem[8'h71] = 32'hFFFF_FFFF;
    mem[8'h72] = 32'h0000_0000;
    mem[8'h73] = 32'h0000_0005;

    rd(32'h00, "R1"); rd(32'h40, "R11"); push(2, 0, 32'h1122_3344, "R11");
    rd(32'h01, "R1"); push(2, 0, 32'hFF80_0005, "R5");
    rd(32'h02, "R1"); push(2, 0, 32'h0000_0123, "R5");
    rd(32'h03, "R1"); rd(32'h41, "R6"); rd(32'h42, "R6"); push(2, 0, 32'hA5A5_A5A5, "R6");
    rd(32'h04, "R1"); rd(32'h40, "R7"); push(2, 0, 32'h1122_3344, "R7");
    rd(32'h05, "R1"); rd(32'h43, "R6"); rd(32'h60, "R7"); push(2, 0, 32'h600D_0000, "R7");
    rd(32'h06, "R1"); push(2, 1, 32'h0123_4567, "R3");
    rd(32'h07, "R1"); push(2, 2, 32'h7800_0010, "R4");
    rd(32'h08, "R1"); push(1, 32'h70, ACC, "R9");
    rd(32'h09, "R1"); rd(32'h71, "R10"); push(1, 32'h71, 32'h0, "R10", 1, 1, 0);
    rd(32'h0A, "R1"); rd(32'h72, "R10"); push(1, 32'h72, 32'hFFFF_FFFF, "R10", 1, 0, 1);
    rd(32'h0B, "R1"); rd(32'h73, "R10"); push(1, 32'h73, 32'h4, "R10", 1, 0, 0);
    rd(32'h0C, "R1"); rd(32'h20, "R8"); rd(32'h90, "R8");
    rd(32'h40, "R2"); push(2, 0, 32'h1122_3344, "R2");

    repeat (3) @(negedge clk_i);
    check(pc_o == '0, "R12 pc in reset", {8'h0, pc_o}, 0);
    check(!mem_rd_o && !mem_wr_o && !exec_req_o, "R12 idle in reset",
          {29'h0, mem_rd_o, mem_wr_o, exec_req_o}, 0);
    check(mem_addr_o == '0, "R12 ma in reset", {8'h0, mem_addr_o}, 0);
    running = 1'b1;
    rst_ni = 1'b1;
    ix_ld_i = 1'b1; ix_d_i = 32'h0000_0010;
    @(negedge clk_i);
    ix_ld_i = 1'b0;
    wait (q.size() == 0);
    running = 1'b0;
    repeat (4) @(negedge clk_i);
    check(mem[8'h70] == ACC, "R9 stored word", mem[8'h70], ACC);
    check(mem[8'h71] == 32'h0, "R10 incremented word", mem[8'h71], 0);
    check(mem[8'h72] == 32'hFFFF_FFFF, "R10 decremented word", mem[8'h72], 32'hFFFF_FFFF);
    check(pc_o == 24'h92 || pc_o == 24'h91, "R8 parked pc", {8'h0, pc_o}, 32'h91);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule